// File: doc/BRIEF.md
# Page write buffer controller

This block sits between a serial bus slave front end and a byte-organised non-volatile array. It collects the data bytes of one write transfer into a page-sized staging buffer. It remembers which buffer slots were filled since the last address. When the transfer is closed it commits the page to the array in a single write pulse that carries a byte-enable mask. The array is split into pages: the upper address bits choose the page, and the lower bits choose a byte slot inside it. While bytes arrive, only the slot pointer advances, and it wraps inside the page.

The front end reports bus events as single-cycle strobes in the system clock domain:
- START seen
- starting address received
- the moment at which the write-protect level must be sampled
- each data byte
- STOP seen

The block answers with two levels. `accept_o` tells the front end to acknowledge data bytes. `busy_o` tells it to ignore the bus during the timed write cycle. The length of the write cycle is a parameter counted in clocks.

States:
- `ST_IDLE` waits for an address (transition *take_addr* to `ST_ARMED`).
- `ST_ARMED` waits for the protect sample. *wp_clear* leads to `ST_LOAD` and *wp_set* leads to `ST_REJECT`. START or STOP leads back to `ST_IDLE` (*drop*).
- `ST_LOAD` stores bytes. It leaves by *commit* (STOP with at least one byte) to `ST_COMMIT`, or by *drop* (START, or STOP with nothing loaded) to `ST_IDLE`.
- `ST_REJECT` swallows bytes until START or STOP (*drop*).
- `ST_COMMIT` issues the array write for one cycle and moves to `ST_BUSY` (*arm_timer*).
- `ST_BUSY` holds until the timer ends (*expire*) and then returns to `ST_IDLE`.

Top module: `page_write_buffer`

## Requirements
- R1: After reset `busy_o`, `accept_o`, `mem_we_o` are 0 and `mem_be_o` is all zero.
- R2: The page driven on `mem_page_o` at commit equals `addr_i[10:4]` of the starting address, whatever the number of bytes loaded.
- R3: The k-th accepted byte (k from 0) lands in slot `(addr_i[3:0] + k) mod 16`, which is data lane `mem_data_o[8*slot +: 8]` and enable bit `mem_be_o[slot]`.
- R4: When more than 16 bytes are loaded, the pointer wraps and a slot holds the last byte written to it.
- R5: At commit, `mem_be_o` has a 1 exactly for the slots loaded since the address; array bytes of unloaded slots keep their previous value.
- R6: `mem_we_o` pulses for exactly one cycle, in the cycle after the STOP strobe is sampled, and only if at least one byte was loaded; a STOP with no data bytes (address-only poll or empty transfer) produces no pulse.
- R7: `busy_o` is high for exactly `WR_CYCLES` cycles starting with the commit cycle; during that time `accept_o` is 0 and address, protect, byte and STOP strobes have no effect.
- R8: If `wp_i` is 1 when `wp_strobe_i` is sampled, `accept_o` stays 0, following bytes are dropped and no array write happens.
- R9: If `wp_i` is 0 at the sample, `accept_o` goes to 1 in the next cycle and the transfer proceeds normally.
- R10: A data byte presented in the same cycle as STOP is stored and included in the commit.
- R11: A START strobe during loading discards the buffered bytes; a later STOP writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START condition strobe |
| addr_valid_i | input | 1 | Starting address strobe |
| addr_i | input | 11 | Starting byte address (page, slot) |
| wp_strobe_i | input | 1 | Sample point for the protect level |
| wp_i | input | 1 | Write-protect level, 1 = protected |
| byte_valid_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | STOP condition strobe |
| accept_o | output | 1 | Data bytes are to be acknowledged |
| busy_o | output | 1 | Write cycle in progress, bus ignored |
| mem_we_o | output | 1 | Single-cycle page write to the array |
| mem_page_o | output | 7 | Page number of the write |
| mem_be_o | output | 16 | Per-slot byte enables |
| mem_data_o | output | 128 | Page data, slot s in bits 8s+7..8s |

## Verification
The last data byte and the STOP strobe can arrive in the same clock cycle. The buffer must then take the byte while the state machine decides whether to commit, so the commit test has to count that byte as loaded. The sweep drives every starting slot with a range of byte counts, and on alternate transfers it places the final byte on the STOP cycle. The enable mask and the array page are then compared with values the bench derives from the slot arithmetic alone. A second collision puts new address, protect, byte and STOP strobes inside the busy window. It is judged by the absence of a second write pulse and by unchanged array contents.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_LOAD,
        ST_REJECT,
        ST_COMMIT,
        ST_BUSY
    } pwb_state_e;

endpackage

// File: rtl/pwb_pointer.sv
module pwb_pointer #(
    parameter int PG_W  = 7,
    parameter int OFF_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [PG_W+OFF_W-1:0]  addr_i,
    input  logic                   step_i,
    output logic [PG_W-1:0]        page_o,
    output logic [OFF_W-1:0]       slot_o
);

    logic [PG_W-1:0]  page_q;
    logic [OFF_W-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            slot_q <= '0;
        end else if (load_i) begin
            page_q <= addr_i[PG_W+OFF_W-1:OFF_W];
            slot_q <= addr_i[OFF_W-1:0];
        end else if (step_i) begin
            slot_q <= slot_q + OFF_W'(1);
        end
    end

    assign page_o = page_q;
    assign slot_o = slot_q;

    // R2
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i) |=> $stable(page_q));

endmodule

// File: rtl/pwb_store.sv
module pwb_store #(
    parameter int SLOTS = 16,
    parameter int OFF_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 wr_i,
    input  logic [OFF_W-1:0]     slot_i,
    input  logic [7:0]           data_i,
    output logic [SLOTS*8-1:0]   data_o,
    output logic [SLOTS-1:0]     mask_o
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [7:0] byte_q;
        logic       used_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
                used_q <= 1'b0;
            end else if (clear_i) begin
                used_q <= 1'b0;
            end else if (wr_i && (slot_i == OFF_W'(g))) begin
                byte_q <= data_i;
                used_q <= 1'b1;
            end
        end

        assign data_o[g*8 +: 8] = byte_q;
        assign mask_o[g]        = used_q;
    end

    // R5
    mask_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i) |=> ((mask_o & $past(mask_o)) == $past(mask_o)));

    // R3
    one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !wr_i) |=> $stable(mask_o));

endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
    parameter int CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);

    localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done_o = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= CNT_W'(1);
        end else if (done_o) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
    import pwb_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int PAGE_COUNT = 128,
    parameter int WR_CYCLES  = 250000
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic                                             start_i,
    input  logic                                             addr_valid_i,
    input  logic [$clog2(PAGE_COUNT)+$clog2(PAGE_BYTES)-1:0] addr_i,
    input  logic                                             wp_strobe_i,
    input  logic                                             wp_i,
    input  logic                                             byte_valid_i,
    input  logic [7:0]                                       byte_i,
    input  logic                                             stop_i,
    output logic                                             accept_o,
    output logic                                             busy_o,
    output logic                                             mem_we_o,
    output logic [$clog2(PAGE_COUNT)-1:0]                    mem_page_o,
    output logic [PAGE_BYTES-1:0]                            mem_be_o,
    output logic [PAGE_BYTES*8-1:0]                          mem_data_o
);

    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = $clog2(PAGE_COUNT);

    pwb_state_e state_q, state_d;

    logic             ptr_load, buf_clear, buf_wr, tmr_start, tmr_done;
    logic             has_bytes;
    logic [OFF_W-1:0] slot;
    logic [PAGE_BYTES-1:0] mask;

    assign has_bytes = (|mask) || byte_valid_i;

    pwb_pointer #(.PG_W(PG_W), .OFF_W(OFF_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ptr_load),
        .addr_i (addr_i),
        .step_i (buf_wr),
        .page_o (mem_page_o),
        .slot_o (slot)
    );

    pwb_store #(.SLOTS(PAGE_BYTES), .OFF_W(OFF_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (buf_clear),
        .wr_i    (buf_wr),
        .slot_i  (slot),
        .data_i  (byte_i),
        .data_o  (mem_data_o),
        .mask_o  (mask)
    );

    pwb_timer #(.CYCLES(WR_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .done_o  (tmr_done)
    );

    assign mem_be_o = mask;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (addr_valid_i) state_d = ST_ARMED;
            ST_ARMED: begin
                if (start_i || stop_i)  state_d = ST_IDLE;
                else if (wp_strobe_i)   state_d = wp_i ? ST_REJECT : ST_LOAD;
            end
            ST_LOAD: begin
                if (start_i)            state_d = ST_IDLE;
                else if (stop_i)        state_d = has_bytes ? ST_COMMIT : ST_IDLE;
            end
            ST_REJECT: if (start_i || stop_i) state_d = ST_IDLE;
            ST_COMMIT: state_d = ST_BUSY;
            ST_BUSY:   if (tmr_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        accept_o  = 1'b0;
        busy_o    = 1'b0;
        mem_we_o  = 1'b0;
        ptr_load  = 1'b0;
        buf_clear = 1'b0;
        buf_wr    = 1'b0;
        tmr_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ptr_load  = addr_valid_i;
                buf_clear = addr_valid_i;
            end
            ST_ARMED:  buf_clear = start_i;
            ST_LOAD: begin
                accept_o  = 1'b1;
                buf_wr    = byte_valid_i && !start_i;
                buf_clear = start_i;
            end
            ST_REJECT: ;
            ST_COMMIT: begin
                busy_o    = 1'b1;
                mem_we_o  = 1'b1;
                tmr_start = 1'b1;
            end
            ST_BUSY: begin
                busy_o    = 1'b1;
                buf_clear = tmr_done;
            end
            default: ;
        endcase
    end

    // R6
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    // R6
    we_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_be_o != '0));

    // R7
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !accept_o);

    // R7
    busy_follows_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> busy_o);

endmodule

// File: tb/page_write_buffer_test.sv
module page_write_buffer_test;

    localparam int CLK_P = 10;
    localparam int WRC   = 12;
    localparam int NB    = 16;
    localparam int NP    = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0, addr_valid_i = 1'b0, wp_strobe_i = 1'b0, wp_i = 1'b0;
    logic         byte_valid_i = 1'b0, stop_i = 1'b0;
    logic [10:0]  addr_i = '0;
    logic [7:0]   byte_i = '0;
    logic         accept_o, busy_o, mem_we_o;
    logic [6:0]   mem_page_o;
    logic [15:0]  mem_be_o;
    logic [127:0] mem_data_o;

    logic [7:0] mem_m [0:NB*NP-1];
    logic [7:0] ref_m [0:NB*NP-1];

    int total = 0, bad = 0, we_cnt = 0;
    bit done_flag = 0;

    always #(CLK_P/2) clk = ~clk;

    page_write_buffer #(.PAGE_BYTES(NB), .PAGE_COUNT(NP), .WR_CYCLES(WRC)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_valid_i(addr_valid_i),
        .addr_i(addr_i), .wp_strobe_i(wp_strobe_i), .wp_i(wp_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i), .stop_i(stop_i),
        .accept_o(accept_o), .busy_o(busy_o), .mem_we_o(mem_we_o),
        .mem_page_o(mem_page_o), .mem_be_o(mem_be_o), .mem_data_o(mem_data_o)
    );

    // array model fed by the write port
    always @(posedge clk) begin
        if (rst_n && mem_we_o) begin
            we_cnt++;
            for (int s = 0; s < NB; s++)
                if (mem_be_o[s]) mem_m[int'(mem_page_o)*NB + s] = mem_data_o[s*8 +: 8];
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic pulse_start;
        start_i = 1; @(negedge clk); start_i = 0;
    endtask

    task automatic pulse_addr(input int a);
        addr_valid_i = 1; addr_i = 11'(a); @(negedge clk); addr_valid_i = 0;
    endtask

    task automatic pulse_wp(input bit lvl);
        wp_i = lvl; wp_strobe_i = 1; @(negedge clk); wp_strobe_i = 0; wp_i = 0;
    endtask

    task automatic pulse_byte(input logic [7:0] d, input bit with_stop);
        byte_valid_i = 1; byte_i = d; stop_i = with_stop;
        @(negedge clk);
        byte_valid_i = 0; stop_i = 0;
    endtask

    task automatic pulse_stop;
        stop_i = 1; @(negedge clk); stop_i = 0;
    endtask

    function automatic logic [7:0] pat(input int pg, input int off, input int n, input int k);
        return 8'((pg*37 + off*11 + k*23 + n*5) & 255);
    endfunction

    task automatic page_chk(input int pg, input string req);
        bit ok = 1; int act = 0, exp = 0;
        for (int s = 0; s < NB; s++)
            if (ok && mem_m[pg*NB+s] !== ref_m[pg*NB+s]) begin
                ok = 0; act = int'(mem_m[pg*NB+s]); exp = int'(ref_m[pg*NB+s]);
            end
        chk(ok, req, act, exp);
    endtask

    task automatic wait_busy_end(input int exp_left);
        int c = 0;
        while (busy_o === 1'b1 && c < WRC + 5) begin
            c++; @(negedge clk);
        end
        chk(c == exp_left, "R7 busy length", c, exp_left);
    endtask

    task automatic write_txn(input int pg, input int off, input int n,
                             input bit merge, input bit wait_busy);
        logic [15:0] expbe = '0;
        pulse_start;
        pulse_addr(pg*NB + off);
        pulse_wp(0);
        chk(accept_o == 1'b1, "R9 accept after low protect", int'(accept_o), 1);
        for (int k = 0; k < n; k++) begin
            pulse_byte(pat(pg, off, n, k), merge && (k == n-1));
            expbe[(off+k) % NB] = 1'b1;
            ref_m[pg*NB + (off+k) % NB] = pat(pg, off, n, k);
        end
        if (!merge) pulse_stop;
        chk(mem_we_o == 1'b1, "R6 write pulse after STOP", int'(mem_we_o), 1);
        chk(mem_be_o == expbe, merge ? "R10 byte with STOP enables" : "R5 enables",
            int'(mem_be_o), int'(expbe));
        chk(int'(mem_page_o) == pg, "R2 page", int'(mem_page_o), pg);
        if (wait_busy) begin
            wait_busy_end(WRC);
            page_chk(pg, (n > NB) ? "R4 wrap overwrite" : "R3 slot placement");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=0 exp=1");
        finish_run;
    end

    initial begin
        int nset [8] = '{1, 2, 7, 15, 16, 17, 21, 33};
        int wc0;
        for (int i = 0; i < NB*NP; i++) begin
            mem_m[i] = 8'hFF; ref_m[i] = 8'hFF;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(busy_o == 1'b0,   "R1 busy after reset",   int'(busy_o), 0);
        chk(accept_o == 1'b0, "R1 accept after reset", int'(accept_o), 0);
        chk(mem_we_o == 1'b0, "R1 we after reset",     int'(mem_we_o), 0);
        chk(mem_be_o == '0,   "R1 enables after reset", int'(mem_be_o), 0);

        // sweep: every start slot with a set of lengths, odd ones merge byte and STOP
        for (int off = 0; off < NB; off++)
            for (int idx = 0; idx < 8; idx++)
                write_txn((off*8 + idx*3) % NP, off, nset[idx], idx[0], 1'b1);

        // R8: protected transfer
        wc0 = we_cnt;
        pulse_start; pulse_addr(40*NB + 2); pulse_wp(1);
        chk(accept_o == 1'b0, "R8 accept with protect", int'(accept_o), 0);
        for (int k = 0; k < 4; k++) pulse_byte(8'(k + 8'h5A), 1'b0);
        pulse_stop; @(negedge clk);
        chk(we_cnt == wc0, "R8 no write", we_cnt, wc0);
        chk(busy_o == 1'b0, "R8 not busy", int'(busy_o), 0);
        page_chk(40, "R8 page unchanged");

        // R6: empty transfer and address-only poll
        wc0 = we_cnt;
        pulse_start; pulse_addr(41*NB); pulse_wp(0); pulse_stop; @(negedge clk);
        pulse_start; pulse_addr(42*NB); pulse_stop; @(negedge clk);
        chk(we_cnt == wc0, "R6 no write without bytes", we_cnt, wc0);
        chk(busy_o == 1'b0, "R6 idle after empty stop", int'(busy_o), 0);

        // R11: START during loading
        wc0 = we_cnt;
        pulse_start; pulse_addr(43*NB + 5); pulse_wp(0);
        for (int k = 0; k < 3; k++) pulse_byte(8'(k + 8'h21), 1'b0);
        pulse_start; pulse_stop; @(negedge clk);
        chk(we_cnt == wc0, "R11 abort writes nothing", we_cnt, wc0);
        page_chk(43, "R11 page unchanged");

        // R7: strobes during the write cycle are ignored
        wc0 = we_cnt;
        write_txn(5, 3, 4, 1'b0, 1'b0);
        pulse_addr(9*NB);
        chk(accept_o == 1'b0, "R7 no accept while busy", int'(accept_o), 0);
        pulse_wp(0);
        chk(accept_o == 1'b0, "R7 protect sample ignored", int'(accept_o), 0);
        pulse_byte(8'h11, 1'b0); pulse_byte(8'h22, 1'b0); pulse_stop;
        wait_busy_end(WRC - 5);
        @(negedge clk);
        chk(we_cnt == wc0 + 1, "R7 single write", we_cnt, wc0 + 1);
        chk(accept_o == 1'b0, "R7 idle after cycle", int'(accept_o), 0);
        page_chk(9, "R7 ignored page unchanged");
        page_chk(5, "R3 page after busy test");

        finish_run;
    end

endmodule